// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block brings a DDR2 or DDR3 SDRAM device out of power-up. It starts on a one-cycle start pulse. It then issues the device's initialization commands one at a time on a strobed command port and inserts the long settling waits itself, counting clock cycles. When the last step is done it loads the refresh interval, enables refresh and raises `done`. A memory-type input picks one of two command orderings. The DDR2 ordering uses two auto-refreshes and a pair of output-driver calibration steps. The DDR3 ordering ends with a ZQ calibration command.

Extended mode register cycles pick their target register through bank bits in the internal address. The position of those bits is not fixed. It is computed when the sequence starts, from the column and row geometry codes, the address decode mode and the data bus width. A controller version input gates the decode mode: interleaved decode is used only if the version is at least 0x140, and older versions always use sequential decode. Configuration inputs are captured on the accepted start pulse. The command port is a plain strobe with no back-pressure, so the attached PHY must accept every command in the cycle it is presented.

Top module: `dram_init_seq`

## Requirements
- R1: A synchronous reset, at power-up or in the middle of a sequence, returns the block to idle. `cmd_valid`, `busy`, `done`, `refresh_en`, `dll_reset` and `ocd_default` are then all low.
- R2: A start pulse is accepted only while idle. Acceptance drops `done` and raises `busy` by the next cycle. A start pulse while `busy` is ignored, and so is any change to the configuration inputs after acceptance: the running sequence is unchanged.
- R3: The bank bit offset is built up as follows. Start with the column code plus 9. Add the row code plus 11 unless interleaving is both requested and allowed (`ctrl_version` >= 0x140). Finally add 1 when `narrow_bus` is set, otherwise 2.
- R4: For extended mode commands, `cmd_bank` carries the target register: 1, 2 or 3. `cmd_addr` equals that bank value shifted left by the offset. Every other command has `cmd_bank` = 0 and `cmd_addr` = 0.
- R5: The command codes are 0 NOP, 1 precharge-all, 2 mode set, 3 extended mode set, 4 auto-refresh, 5 ZQ calibration, 6 normal mode and 7 dummy write. The DDR2 order (`mem_is_ddr3` = 0) is 0, 0, 1, 3(bank 2), 3(bank 3), 3(bank 1), 2, 1, 4, 4, 2, 3(bank 1), 3(bank 1), 6, 7.
- R6: In DDR2, `dll_reset` is high for the first mode set, the second precharge-all and both auto-refreshes, and low for the second mode set. `ocd_default` is high only for the first of the last two extended mode sets. Exactly two auto-refreshes are issued. In DDR3, `dll_reset` is high only for the mode set.
- R7: The DDR3 order is 0, 0, 3(bank 2), 3(bank 3), 3(bank 1), 2, 5, 6, 7.
- R8: Waits are ceil(us x `CLK_KHZ` / 1000) cycles. The two leading NOPs are at least the power-up wait apart: 200 us for DDR2, 500 us for DDR3. In DDR3 the ZQ command follows the mode set by at least 50 us.
- R9: Each command strobe lasts one cycle. Consecutive strobes are at least `CMD_GAP` + 1 cycles apart.
- R10: On completion, `refresh_interval` takes the refresh count captured at start. `refresh_en` and `done` rise in the same cycle, and `busy` falls. `done` stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the sequence |
| mem_is_ddr3 | input | 1 | 1 selects the DDR3 ordering, 0 the DDR2 ordering |
| col_code | input | 2 | Column-count code |
| row_code | input | 2 | Row-count code |
| narrow_bus | input | 1 | Narrow data bus flag |
| interleave_req | input | 1 | Requests interleaved bank decode |
| ctrl_version | input | 16 | Controller version; gates interleaving |
| refresh_count | input | RC_W | Refresh interval to load at completion |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 3 | Command code (see R5) |
| cmd_bank | output | 2 | Bank-select value for the command |
| cmd_addr | output | ADDR_W | Internal address with the bank bits placed |
| dll_reset | output | 1 | DLL-reset configuration bit |
| ocd_default | output | 1 | Driver-calibration default bit |
| refresh_interval | output | RC_W | Loaded refresh interval |
| refresh_en | output | 1 | Refresh enabled |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence complete |

## Verification
A start pulse can land in the same cycle the sequencer is doing something else. It can arrive during a long wait or right next to a command strobe. The bench provokes this by pulsing `start` mid-run with the memory type and column code flipped. It then judges the recorded command stream against the ordering and addresses of the original configuration. A synchronous reset landing mid-sequence is checked the same way: every output must be idle one cycle later.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_PREA   = 3'd1,
    CMD_MRS    = 3'd2,
    CMD_EMRS   = 3'd3,
    CMD_REF    = 3'd4,
    CMD_ZQ     = 3'd5,
    CMD_NORMAL = 3'd6,
    CMD_WRITE  = 3'd7
  } dram_cmd_e;

  typedef enum logic [2:0] {
    OP_CMD, OP_WAIT, OP_DLL_ON, OP_DLL_OFF, OP_OCD_ON, OP_OCD_OFF, OP_END
  } step_op_e;

  typedef enum logic [1:0] {
    WT_PWR_D2 = 2'd0,
    WT_PWR_D3 = 2'd1,
    WT_DLL_D3 = 2'd2
  } wait_sel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_GAP, ST_WAIT} seq_state_e;

  typedef struct packed {
    step_op_e  op;
    dram_cmd_e cmd;
    logic [1:0] bank;
    wait_sel_e wsel;
  } step_t;

  localparam int IDX_W = 5;
  localparam int OFS_W = 5;
  localparam logic [15:0] INTERLEAVE_MIN_VER = 16'h0140;

  function automatic step_t mk(step_op_e op, dram_cmd_e cmd, logic [1:0] bank, wait_sel_e ws);
    step_t s;
    s.op = op; s.cmd = cmd; s.bank = bank; s.wsel = ws;
    return s;
  endfunction

endpackage

// File: rtl/init_bank_offset.sv
module init_bank_offset
  import dram_init_pkg::*;
(
  input  logic [1:0]       col_code,
  input  logic [1:0]       row_code,
  input  logic             narrow_bus,
  input  logic             interleave_req,
  input  logic [15:0]      ctrl_version,
  output logic [OFS_W-1:0] offset
);
  logic sequential;
  assign sequential = !(interleave_req && (ctrl_version >= INTERLEAVE_MIN_VER));

  always_comb begin
    offset = OFS_W'(9) + OFS_W'(col_code);
    if (sequential) offset = offset + OFS_W'(11) + OFS_W'(row_code);
    offset = offset + (narrow_bus ? OFS_W'(1) : OFS_W'(2));
  end
endmodule

// File: rtl/init_step_rom.sv
module init_step_rom
  import dram_init_pkg::*;
(
  input  logic             is_ddr3,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  always_comb begin
    step = mk(OP_END, CMD_NOP, 2'd0, WT_PWR_D2);
    if (!is_ddr3) begin
      case (idx)
        5'd0:  step = mk(OP_CMD,     CMD_NOP,    2'd0, WT_PWR_D2);
        5'd1:  step = mk(OP_WAIT,    CMD_NOP,    2'd0, WT_PWR_D2);
        5'd2:  step = mk(OP_CMD,     CMD_NOP,    2'd0, WT_PWR_D2);
        5'd3:  step = mk(OP_CMD,     CMD_PREA,   2'd0, WT_PWR_D2);
        5'd4:  step = mk(OP_CMD,     CMD_EMRS,   2'd2, WT_PWR_D2);
        5'd5:  step = mk(OP_CMD,     CMD_EMRS,   2'd3, WT_PWR_D2);
        5'd6:  step = mk(OP_CMD,     CMD_EMRS,   2'd1, WT_PWR_D2);
        5'd7:  step = mk(OP_DLL_ON,  CMD_NOP,    2'd0, WT_PWR_D2);
        5'd8:  step = mk(OP_CMD,     CMD_MRS,    2'd0, WT_PWR_D2);
        5'd9:  step = mk(OP_CMD,     CMD_PREA,   2'd0, WT_PWR_D2);
        5'd10: step = mk(OP_CMD,     CMD_REF,    2'd0, WT_PWR_D2);
        5'd11: step = mk(OP_CMD,     CMD_REF,    2'd0, WT_PWR_D2);
        5'd12: step = mk(OP_DLL_OFF, CMD_NOP,    2'd0, WT_PWR_D2);
        5'd13: step = mk(OP_CMD,     CMD_MRS,    2'd0, WT_PWR_D2);
        5'd14: step = mk(OP_OCD_ON,  CMD_NOP,    2'd0, WT_PWR_D2);
        5'd15: step = mk(OP_CMD,     CMD_EMRS,   2'd1, WT_PWR_D2);
        5'd16: step = mk(OP_OCD_OFF, CMD_NOP,    2'd0, WT_PWR_D2);
        5'd17: step = mk(OP_CMD,     CMD_EMRS,   2'd1, WT_PWR_D2);
        5'd18: step = mk(OP_CMD,     CMD_NORMAL, 2'd0, WT_PWR_D2);
        5'd19: step = mk(OP_CMD,     CMD_WRITE,  2'd0, WT_PWR_D2);
        default: ;
      endcase
    end else begin
      case (idx)
        5'd0:  step = mk(OP_CMD,     CMD_NOP,    2'd0, WT_PWR_D3);
        5'd1:  step = mk(OP_WAIT,    CMD_NOP,    2'd0, WT_PWR_D3);
        5'd2:  step = mk(OP_CMD,     CMD_NOP,    2'd0, WT_PWR_D3);
        5'd3:  step = mk(OP_CMD,     CMD_EMRS,   2'd2, WT_PWR_D3);
        5'd4:  step = mk(OP_CMD,     CMD_EMRS,   2'd3, WT_PWR_D3);
        5'd5:  step = mk(OP_CMD,     CMD_EMRS,   2'd1, WT_PWR_D3);
        5'd6:  step = mk(OP_DLL_ON,  CMD_NOP,    2'd0, WT_PWR_D3);
        5'd7:  step = mk(OP_CMD,     CMD_MRS,    2'd0, WT_PWR_D3);
        5'd8:  step = mk(OP_DLL_OFF, CMD_NOP,    2'd0, WT_PWR_D3);
        5'd9:  step = mk(OP_WAIT,    CMD_NOP,    2'd0, WT_DLL_D3);
        5'd10: step = mk(OP_CMD,     CMD_ZQ,     2'd0, WT_DLL_D3);
        5'd11: step = mk(OP_CMD,     CMD_NORMAL, 2'd0, WT_DLL_D3);
        5'd12: step = mk(OP_CMD,     CMD_WRITE,  2'd0, WT_DLL_D3);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/init_delay_counter.sv
module init_delay_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         active,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - W'(1);
    end
  end

  assign expired = active && (cnt == '0);

  // R8
  countdown_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int CLK_KHZ = 200000,
  parameter int CMD_GAP = 2,
  parameter int ADDR_W  = 32,
  parameter int RC_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mem_is_ddr3,
  input  logic [1:0]        col_code,
  input  logic [1:0]        row_code,
  input  logic              narrow_bus,
  input  logic              interleave_req,
  input  logic [15:0]       ctrl_version,
  input  logic [RC_W-1:0]   refresh_count,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [1:0]        cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              dll_reset,
  output logic              ocd_default,
  output logic [RC_W-1:0]   refresh_interval,
  output logic              refresh_en,
  output logic              busy,
  output logic              done
);
  localparam int W_PWR_D2 = (200 * CLK_KHZ + 999) / 1000;
  localparam int W_PWR_D3 = (500 * CLK_KHZ + 999) / 1000;
  localparam int W_DLL_D3 = (50  * CLK_KHZ + 999) / 1000;
  localparam int CNT_W    = $clog2(W_PWR_D3 + 1);
  localparam int GAP_W    = $clog2(CMD_GAP + 1);

  seq_state_e       st;
  logic [IDX_W-1:0] idx;
  logic             ddr3_q;
  logic [OFS_W-1:0] ofs_in, ofs_q;
  logic [RC_W-1:0]  rc_q;
  step_t            step;
  logic             gap_load, gap_active, gap_exp;
  logic             wait_load, wait_active, wait_exp;
  logic [CNT_W-1:0] wait_val;

  init_bank_offset u_ofs (
    .col_code(col_code), .row_code(row_code), .narrow_bus(narrow_bus),
    .interleave_req(interleave_req), .ctrl_version(ctrl_version), .offset(ofs_in));

  init_step_rom u_rom (.is_ddr3(ddr3_q), .idx(idx), .step(step));

  assign gap_load  = (st == ST_STEP) && (step.op == OP_CMD);
  assign wait_load = (st == ST_STEP) && (step.op == OP_WAIT);

  always_comb begin
    case (step.wsel)
      WT_PWR_D3: wait_val = CNT_W'(W_PWR_D3 - 1);
      WT_DLL_D3: wait_val = CNT_W'(W_DLL_D3 - 1);
      default:   wait_val = CNT_W'(W_PWR_D2 - 1);
    endcase
  end

  init_delay_counter #(.W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(GAP_W'(CMD_GAP - 1)),
    .active(gap_active), .expired(gap_exp));

  init_delay_counter #(.W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .load(wait_load), .load_val(wait_val),
    .active(wait_active), .expired(wait_exp));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; idx <= '0; ddr3_q <= 1'b0; ofs_q <= '0; rc_q <= '0;
      dll_reset <= 1'b0; ocd_default <= 1'b0;
      refresh_interval <= '0; refresh_en <= 1'b0; done <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          ddr3_q <= mem_is_ddr3; ofs_q <= ofs_in; rc_q <= refresh_count;
          idx <= '0; done <= 1'b0; refresh_en <= 1'b0; st <= ST_STEP;
        end
        ST_STEP: begin
          case (step.op)
            OP_CMD:     st <= ST_GAP;
            OP_WAIT:    st <= ST_WAIT;
            OP_DLL_ON:  begin dll_reset   <= 1'b1; idx <= idx + IDX_W'(1); end
            OP_DLL_OFF: begin dll_reset   <= 1'b0; idx <= idx + IDX_W'(1); end
            OP_OCD_ON:  begin ocd_default <= 1'b1; idx <= idx + IDX_W'(1); end
            OP_OCD_OFF: begin ocd_default <= 1'b0; idx <= idx + IDX_W'(1); end
            default: begin
              refresh_interval <= rc_q; refresh_en <= 1'b1; done <= 1'b1;
              st <= ST_IDLE;
            end
          endcase
        end
        ST_GAP:  if (gap_exp)  begin idx <= idx + IDX_W'(1); st <= ST_STEP; end
        default: if (wait_exp) begin idx <= idx + IDX_W'(1); st <= ST_STEP; end
      endcase
    end
  end

  assign cmd_valid = gap_load;
  assign cmd_code  = cmd_valid ? step.cmd : CMD_NOP;
  assign cmd_bank  = (cmd_valid && step.cmd == CMD_EMRS) ? step.bank : 2'd0;
  assign cmd_addr  = {{(ADDR_W-2){1'b0}}, cmd_bank} << ofs_q;
  assign busy      = (st != ST_IDLE);

  // R9
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R9
  cmd_not_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (!gap_active && !wait_active));
  // R4
  plain_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code != CMD_EMRS) |-> (cmd_bank == 2'd0 && cmd_addr == '0));
  // R10
  done_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($rose(refresh_en) && !busy));
  // R10
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  // R2
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(ddr3_q) && $stable(ofs_q)));
  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dll_reset && ocd_default));
endmodule

// File: tb/test_dram_init_seq.sv
`timescale 1ns/1ps
module test_dram_init_seq;
  localparam int CLK_KHZ = 1333;
  localparam int GAP = 2;
  localparam int AW = 32;
  localparam int RW = 12;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic mem_is_ddr3 = 1'b0, narrow_bus = 1'b0, interleave_req = 1'b0;
  logic [1:0] col_code = '0, row_code = '0;
  logic [15:0] ctrl_version = '0;
  logic [RW-1:0] refresh_count = '0;
  logic cmd_valid, dll_reset, ocd_default, refresh_en, busy, done;
  logic [2:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;
  logic [RW-1:0] refresh_interval;

  dram_init_seq #(.CLK_KHZ(CLK_KHZ), .CMD_GAP(GAP), .ADDR_W(AW), .RC_W(RW)) i_dram_init_seq (
    .clk(clk), .rst(rst), .start(start), .mem_is_ddr3(mem_is_ddr3),
    .col_code(col_code), .row_code(row_code), .narrow_bus(narrow_bus),
    .interleave_req(interleave_req), .ctrl_version(ctrl_version),
    .refresh_count(refresh_count), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .dll_reset(dll_reset),
    .ocd_default(ocd_default), .refresh_interval(refresh_interval),
    .refresh_en(refresh_en), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, n = 0, ne = 0, mism = 0;
  bit rec_on = 1'b0, finished = 1'b0;
  logic [2:0] m_cmd[32];  logic [1:0] m_bank[32]; logic [AW-1:0] m_addr[32];
  bit m_dll[32], m_ocd[32]; int m_t[32];
  logic [2:0] e_cmd[32];  logic [1:0] e_bank[32]; bit e_dll[32], e_ocd[32];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && done !== refresh_en) mism++;
    if (rec_on && cmd_valid) begin
      if (n < 32) begin
        m_cmd[n] = cmd_code; m_bank[n] = cmd_bank; m_addr[n] = cmd_addr;
        m_dll[n] = dll_reset; m_ocd[n] = ocd_default; m_t[n] = cyc;
      end
      n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic [1:0] b, input bit d, input bit o);
    e_cmd[ne] = c; e_bank[ne] = b; e_dll[ne] = d; e_ocd[ne] = o; ne++;
  endtask

  function automatic int wcyc(input int us);
    return (us * CLK_KHZ + 999) / 1000;
  endfunction

  task automatic run_case(input bit d3, input logic [1:0] c, input logic [1:0] r, input bit nb,
                          input bit il, input logic [15:0] ver, input logic [RW-1:0] rc, input bit poke);
    int off, bad, refs, mingap;
    @(negedge clk);
    mem_is_ddr3 = d3; col_code = c; row_code = r; narrow_bus = nb;
    interleave_req = il; ctrl_version = ver; refresh_count = rc;
    n = 0; rec_on = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && busy, "R2 accept", {done, busy}, 2'b01);
    if (poke) begin
      repeat (20) @(negedge clk);
      mem_is_ddr3 = ~d3; col_code = ~c; refresh_count = ~rc; start = 1'b1;
      @(negedge clk);
      start = 1'b0; mem_is_ddr3 = d3; col_code = c; refresh_count = rc;
    end
    for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
    rec_on = 1'b0;
    off = 9 + c + ((il && ver >= 16'h0140) ? 0 : r + 11) + (nb ? 1 : 2);
    ne = 0;
    push(0,0,0,0); push(0,0,0,0);
    if (!d3) begin
      push(1,0,0,0); push(3,2,0,0); push(3,3,0,0); push(3,1,0,0);
      push(2,0,1,0); push(1,0,1,0); push(4,0,1,0); push(4,0,1,0);
      push(2,0,0,0); push(3,1,0,1); push(3,1,0,0); push(6,0,0,0); push(7,0,0,0);
    end else begin
      push(3,2,0,0); push(3,3,0,0); push(3,1,0,0); push(2,0,1,0);
      push(5,0,0,0); push(6,0,0,0); push(7,0,0,0);
    end
    chk(n == ne, d3 ? "R7 count" : "R5 count", n, ne);
    if (poke) chk(n == ne, "R2 ignored start", n, ne);
    bad = -1;
    for (int i = 0; i < ne && i < n; i++) if (bad < 0 && m_cmd[i] != e_cmd[i]) bad = i;
    chk(bad < 0, d3 ? "R7 order" : "R5 order", bad < 0 ? 0 : m_cmd[bad], bad < 0 ? 0 : e_cmd[bad]);
    bad = -1;
    for (int i = 0; i < ne && i < n; i++) if (bad < 0 && m_bank[i] != e_bank[i]) bad = i;
    chk(bad < 0, "R4 bank", bad < 0 ? 0 : m_bank[bad], bad < 0 ? 0 : e_bank[bad]);
    bad = -1;
    for (int i = 0; i < ne && i < n; i++)
      if (bad < 0 && m_addr[i] != (AW'(e_bank[i]) << off)) bad = i;
    chk(bad < 0, "R3 offset addr", bad < 0 ? 0 : m_addr[bad],
        bad < 0 ? 0 : (AW'(e_bank[bad]) << off));
    if (poke) chk(bad < 0, "R2 config kept", bad, -1);
    bad = -1;
    for (int i = 0; i < ne && i < n; i++)
      if (bad < 0 && (m_dll[i] != e_dll[i] || m_ocd[i] != e_ocd[i])) bad = i;
    chk(bad < 0, "R6 flags", bad < 0 ? 0 : {m_dll[bad], m_ocd[bad]},
        bad < 0 ? 0 : {e_dll[bad], e_ocd[bad]});
    if (!d3) begin
      refs = 0;
      for (int i = 0; i < n && i < 32; i++) if (m_cmd[i] == 3'd4) refs++;
      chk(refs == 2, "R6 refresh count", refs, 2);
    end
    mingap = 1000000;
    for (int i = 1; i < n && i < 32; i++) if (m_t[i] - m_t[i-1] < mingap) mingap = m_t[i] - m_t[i-1];
    chk(mingap >= GAP + 1, "R9 spacing", mingap, GAP + 1);
    if (n >= 2) chk(m_t[1] - m_t[0] >= wcyc(d3 ? 500 : 200), "R8 powerup wait",
                    m_t[1] - m_t[0], wcyc(d3 ? 500 : 200));
    if (d3 && n >= 7) chk(m_t[6] - m_t[5] >= wcyc(50), "R8 dll wait", m_t[6] - m_t[5], wcyc(50));
    chk(done && !busy && refresh_en, "R10 finish", {done, busy, refresh_en}, 3'b101);
    chk(refresh_interval == rc, "R10 interval", refresh_interval, rc);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!cmd_valid && !busy && !done && !refresh_en && !dll_reset && !ocd_default,
        "R1 reset", {cmd_valid, busy, done, refresh_en, dll_reset, ocd_default}, 0);
    rst = 1'b0;
    // R3/R4/R5/R6: full geometry sweep of DDR2, both sides of the version threshold
    for (int v = 0; v < 2; v++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          for (int nb = 0; nb < 2; nb++)
            for (int il = 0; il < 2; il++)
              run_case(1'b0, 2'(c), 2'(r), nb[0], il[0], v ? 16'h0140 : 16'h013F,
                       RW'(c * 64 + r * 8 + nb * 2 + il + 1), 1'b0);
    // R7/R8: DDR3 geometry sweep
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        run_case(1'b1, 2'(c), 2'(r), r[0], c[0], 16'h0200, RW'(12'h700 + c * 4 + r), 1'b0);
    // R10: done holds while idle
    repeat (40) @(negedge clk);
    chk(done && refresh_en, "R10 done held", {done, refresh_en}, 2'b11);
    // R2: start during running sequences is ignored
    run_case(1'b0, 2'd1, 2'd2, 1'b0, 1'b1, 16'h0140, 12'h123, 1'b1);
    run_case(1'b1, 2'd2, 2'd3, 1'b1, 1'b0, 16'h0100, 12'h456, 1'b1);
    // R1: reset in the middle of a run
    @(negedge clk);
    mem_is_ddr3 = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!cmd_valid && !busy && !done && !refresh_en && !dll_reset && !ocd_default,
        "R1 mid-run reset", {cmd_valid, busy, done, refresh_en, dll_reset, ocd_default}, 0);
    repeat (20) @(negedge clk);
    chk(!busy && !cmd_valid, "R1 stays idle", {busy, cmd_valid}, 0);
    chk(mism == 0, "R10 done/refresh_en together", mism, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule